// File: doc/BRIEF.md
# Shared-Bus Wishbone Fabric

This block lets four Wishbone masters reach a set of Wishbone slaves through one common bus. A round-robin arbiter chooses the master that owns the bus. The owner's address, write data, byte selects, write enable, cycle and strobe drive the shared bus. Address, write data, byte selects and write enable go to every slave in parallel. The cycle and strobe qualifiers reach only the slave that the two most significant word-address bits select.

There are four decode slots. Slaves sit in slots 0, 1 and 3. Slot 2 is empty, and an internal responder answers accesses to it, so a stray access still ends. The acknowledge and read data of the addressed slave go back only to the master that holds the grant. Every other master sees acknowledge low and read data zero, and has to keep its request up until it is served. Bursts, error and retry, and pipelined handshakes are not supported.

Top module: `wb_shared_fabric`

## Requirements
- R1: While reset is asserted and on the first cycle after it, no master is granted. Every slave cycle and strobe output is low, and every master acknowledge is low.
- R2: While the granted master holds its cycle input high, the grant stays with it. Requests from other masters have no effect on the grant.
- R3: When nobody owns the bus, the grant is evaluated at the next clock edge. An owner counts as gone once its cycle input is low at an edge. The search starts at the master after the last owner, in ascending index order with wrap-around, and the first master with its cycle input high is granted. After reset the search starts at master 0.
- R4: The shared address, write data, byte selects and write enable outputs equal those of the granted master. They are all zero when no master is granted. A slave cycle output is high only while the granted master holds its cycle input high.
- R5: The decoded slot is bits [29:28] of the 30-bit word address. Only the cycle and strobe outputs of that slot follow the granted master's cycle and strobe, and at most one slave cycle output is high at a time.
- R6: The granted master's acknowledge follows the decoded slave's acknowledge, gated by the bus strobe. Its read data equals that slave's read data. A master without the grant sees acknowledge 0 and read data 0.
- R7: An access to slot 2 drives no slave cycle output. The granted master is acknowledged in the same cycle as its strobe and reads zero. The slot 2 acknowledge and read data inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| m_adr_i | input | 4*30 | Word address per master, master k at bits [30k+29:30k] |
| m_dat_i | input | 4*32 | Write data per master |
| m_sel_i | input | 4*4 | Byte selects per master |
| m_we_i | input | 4 | Write enable per master |
| m_cyc_i | input | 4 | Cycle (bus request) per master |
| m_stb_i | input | 4 | Strobe per master |
| m_dat_o | output | 4*32 | Read data per master |
| m_ack_o | output | 4 | Acknowledge per master |
| s_adr_o | output | 30 | Shared word address |
| s_dat_o | output | 32 | Shared write data |
| s_sel_o | output | 4 | Shared byte selects |
| s_we_o | output | 1 | Shared write enable |
| s_cyc_o | output | 4 | Cycle per decode slot |
| s_stb_o | output | 4 | Strobe per decode slot |
| s_dat_i | input | 4*32 | Read data per decode slot |
| s_ack_i | input | 4 | Acknowledge per decode slot |

## Verification
The assertions check four things on every cycle. At most one slave cycle is active and at most one master is acknowledged, and only the owner can be acknowledged. An owner keeps the grant while its cycle is held, and a waiting request gets a grant at the next edge. An access to the empty slot is always acknowledged without reaching a slave. The directed scenarios show what needs known stimulus and expected values. These are the round-robin order across several handovers, including skipping idle masters and wrapping past the highest index. They also cover the exact forwarding of address, data, selects and write enable, and the read data each slave returns. Finally they show that the slot 2 inputs are ignored even when driven with nonzero values.

// File: rtl/wbf_pkg.sv
// Shared constants and bus bundle for the shared-bus fabric.
// Assumes a 30-bit word address whose two top bits pick the slot.
package wbf_pkg;
    localparam int unsigned WBF_AW    = 30;
    localparam int unsigned WBF_DW    = 32;
    localparam int unsigned WBF_SW    = WBF_DW / 8;
    localparam int unsigned WBF_DEC   = 2;
    localparam int unsigned WBF_SLOTS = 1 << WBF_DEC;

    typedef logic [WBF_DEC-1:0] wbf_slot_t;

    // One master-side request bundle; every port uses this layout.
    typedef struct packed {
        logic [WBF_AW-1:0] adr;
        logic [WBF_DW-1:0] dat;
        logic [WBF_SW-1:0] sel;
        logic              we;
        logic              cyc;
        logic              stb;
    } wbf_bus_t;

    // Slot index carried by the top bits of a word address.
    function automatic wbf_slot_t wbf_slot_of(input logic [WBF_AW-1:0] a);
        return a[WBF_AW-1 -: WBF_DEC];
    endfunction
endpackage

// File: rtl/wbf_rr_arbiter.sv
// Round-robin owner selection for the shared bus.
// The owner keeps the grant while its request is held. A new owner is
// searched for only when the bus is free, starting after the last owner.
module wbf_rr_arbiter #(
    parameter int unsigned NM = 4,
    parameter int unsigned IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NM-1:0] req,
    output logic          gnt_vld,
    output logic [IW-1:0] gnt_idx
);
    logic          hold;
    logic          found;
    logic [IW-1:0] nxt_idx;

    // Owner still requesting: keep the grant.
    assign hold = gnt_vld && req[gnt_idx];

    // Circular search beginning one past the last owner.
    always_comb begin
        found   = 1'b0;
        nxt_idx = gnt_idx;
        for (int k = 1; k <= int'(NM); k++) begin
            int cand;
            cand = (int'(gnt_idx) + k) % int'(NM);
            if (!found && req[cand]) begin
                found   = 1'b1;
                nxt_idx = IW'(cand);
            end
        end
    end

    // Grant register; the last index is kept as the search origin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_vld <= 1'b0;
            gnt_idx <= IW'(NM - 1);
        end else if (!hold) begin
            gnt_vld <= found;
            if (found) begin
                gnt_idx <= nxt_idx;
            end
        end
    end
endmodule

// File: rtl/wbf_master_mux.sv
// Puts the owner's request bundle onto the shared bus.
// Assumes gnt_idx is in range whenever gnt_vld is high.
// The bus is all zero while nobody is granted.
module wbf_master_mux
    import wbf_pkg::*;
#(
    parameter int unsigned NM = 4,
    parameter int unsigned IW = 2
) (
    input  wbf_bus_t      m_bus [NM],
    input  logic          gnt_vld,
    input  logic [IW-1:0] gnt_idx,
    output wbf_bus_t      bus
);
    // Select the owner's bundle, or an idle bus.
    always_comb begin
        bus = '0;
        if (gnt_vld) begin
            bus = m_bus[gnt_idx];
        end
    end
endmodule

// File: rtl/wbf_slave_route.sv
// Slot decoder, cycle qualification and return path.
// Populated slots get cycle/strobe only when addressed. Empty slots
// are answered by a zero-data responder, and their inputs are ignored.
module wbf_slave_route
    import wbf_pkg::*;
#(
    parameter logic [WBF_SLOTS-1:0] POP = 4'b1011
) (
    input  wbf_bus_t                      bus,
    output logic [WBF_SLOTS-1:0]          s_cyc_o,
    output logic [WBF_SLOTS-1:0]          s_stb_o,
    input  logic [WBF_SLOTS*WBF_DW-1:0]   s_dat_i,
    input  logic [WBF_SLOTS-1:0]          s_ack_i,
    output logic                          ret_ack,
    output logic [WBF_DW-1:0]             ret_dat
);
    wbf_slot_t             slot;
    logic [WBF_SLOTS-1:0]  hit;
    logic [WBF_SLOTS-1:0]  ack_v;
    logic [WBF_DW-1:0]     dat_v [WBF_SLOTS];
    logic [WBF_SLOTS-1:0]  unused_hole_ack;
    logic [WBF_SLOTS-1:0]  unused_hole_dat;

    assign slot = wbf_slot_of(bus.adr);

    // One-hot slot hit from the top address bits.
    always_comb begin
        hit       = '0;
        hit[slot] = 1'b1;
    end

    for (genvar k = 0; k < int'(WBF_SLOTS); k++) begin : g_slot
        if (POP[k]) begin : g_pop
            // Real slave: qualified cycle, its own response.
            assign s_cyc_o[k]         = bus.cyc & hit[k];
            assign s_stb_o[k]         = bus.stb & bus.cyc & hit[k];
            assign ack_v[k]           = s_ack_i[k];
            assign dat_v[k]           = s_dat_i[k*WBF_DW +: WBF_DW];
            assign unused_hole_ack[k] = 1'b0;
            assign unused_hole_dat[k] = 1'b0;
        end else begin : g_hole
            // Empty slot: no slave cycle, immediate zero-data ack.
            assign s_cyc_o[k]         = 1'b0;
            assign s_stb_o[k]         = 1'b0;
            assign ack_v[k]           = bus.cyc & bus.stb & hit[k];
            assign dat_v[k]           = '0;
            assign unused_hole_ack[k] = s_ack_i[k];
            assign unused_hole_dat[k] = ^s_dat_i[k*WBF_DW +: WBF_DW];
        end
    end

    // Response of the addressed slot, valid only during a strobe.
    assign ret_ack = bus.cyc & bus.stb & ack_v[slot];
    assign ret_dat = dat_v[slot];
endmodule

// File: rtl/wb_shared_fabric.sv
// Shared-bus fabric: NM masters, WBF_SLOTS decode slots.
// Flattened master vectors are unpacked into bundles, arbitrated and
// routed. Only the owner receives acknowledge and read data.
module wb_shared_fabric
    import wbf_pkg::*;
#(
    parameter int unsigned          NM  = 4,
    parameter logic [WBF_SLOTS-1:0] POP = 4'b1011
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NM*WBF_AW-1:0]        m_adr_i,
    input  logic [NM*WBF_DW-1:0]        m_dat_i,
    input  logic [NM*WBF_SW-1:0]        m_sel_i,
    input  logic [NM-1:0]               m_we_i,
    input  logic [NM-1:0]               m_cyc_i,
    input  logic [NM-1:0]               m_stb_i,
    output logic [NM*WBF_DW-1:0]        m_dat_o,
    output logic [NM-1:0]               m_ack_o,
    output logic [WBF_AW-1:0]           s_adr_o,
    output logic [WBF_DW-1:0]           s_dat_o,
    output logic [WBF_SW-1:0]           s_sel_o,
    output logic                        s_we_o,
    output logic [WBF_SLOTS-1:0]        s_cyc_o,
    output logic [WBF_SLOTS-1:0]        s_stb_o,
    input  logic [WBF_SLOTS*WBF_DW-1:0] s_dat_i,
    input  logic [WBF_SLOTS-1:0]        s_ack_i
);
    localparam int unsigned IW = (NM > 1) ? $clog2(NM) : 1;

    wbf_bus_t          m_bus [NM];
    wbf_bus_t          bus;
    logic              gnt_vld;
    logic [IW-1:0]     gnt_idx;
    logic              ret_ack;
    logic [WBF_DW-1:0] ret_dat;

    for (genvar g = 0; g < int'(NM); g++) begin : g_mst
        // Gather one master's flattened signals into a bundle.
        assign m_bus[g] = '{
            adr: m_adr_i[g*WBF_AW +: WBF_AW],
            dat: m_dat_i[g*WBF_DW +: WBF_DW],
            sel: m_sel_i[g*WBF_SW +: WBF_SW],
            we:  m_we_i[g],
            cyc: m_cyc_i[g],
            stb: m_stb_i[g]
        };
        // Return path reaches only the owner.
        assign m_ack_o[g] = gnt_vld && (gnt_idx == IW'(g)) && ret_ack;
        assign m_dat_o[g*WBF_DW +: WBF_DW] =
            (gnt_vld && (gnt_idx == IW'(g))) ? ret_dat : '0;
    end

    wbf_rr_arbiter #(.NM(NM), .IW(IW)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (m_cyc_i),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    wbf_master_mux #(.NM(NM), .IW(IW)) u_mux (
        .m_bus   (m_bus),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx),
        .bus     (bus)
    );

    wbf_slave_route #(.POP(POP)) u_route (
        .bus     (bus),
        .s_cyc_o (s_cyc_o),
        .s_stb_o (s_stb_o),
        .s_dat_i (s_dat_i),
        .s_ack_i (s_ack_i),
        .ret_ack (ret_ack),
        .ret_dat (ret_dat)
    );

    // Shared, unqualified signals go to every slave.
    assign s_adr_o = bus.adr;
    assign s_dat_o = bus.dat;
    assign s_sel_o = bus.sel;
    assign s_we_o  = bus.we;
endmodule

// File: rtl/wbf_checker.sv
// Protocol checks for wb_shared_fabric, attached by bind.
module wbf_checker
    import wbf_pkg::*;
#(
    parameter int unsigned          NM  = 4,
    parameter int unsigned          IW  = 2,
    parameter logic [WBF_SLOTS-1:0] POP = 4'b1011
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NM*WBF_AW-1:0]  m_adr_i,
    input logic [NM-1:0]         m_cyc_i,
    input logic [NM-1:0]         m_stb_i,
    input logic [NM-1:0]         m_ack_o,
    input logic [WBF_SLOTS-1:0]  s_cyc_o,
    input logic                  gnt_vld,
    input logic [IW-1:0]         gnt_idx
);
    logic [WBF_AW-1:0] own_adr;
    logic              own_stb;

    assign own_adr = m_adr_i[gnt_idx*WBF_AW +: WBF_AW];
    assign own_stb = gnt_vld && m_cyc_i[gnt_idx] && m_stb_i[gnt_idx];

    AST_ONE_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_cyc_o)); // R5

    AST_ACK_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (|m_ack_o) |-> (gnt_vld && m_ack_o == (NM'(1) << gnt_idx))); // R6

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld && m_cyc_i[gnt_idx]) |=> (gnt_vld && gnt_idx == $past(gnt_idx))); // R2

    AST_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_vld && (|m_cyc_i)) |=> gnt_vld); // R3

    AST_CYC_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (|s_cyc_o) |-> (gnt_vld && m_cyc_i[gnt_idx])); // R4

    AST_HOLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (own_stb && !POP[wbf_slot_of(own_adr)]) |-> (m_ack_o[gnt_idx] && s_cyc_o == '0)); // R7
endmodule

bind wb_shared_fabric wbf_checker #(.NM(NM), .IW(IW), .POP(POP)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .m_adr_i (m_adr_i),
    .m_cyc_i (m_cyc_i),
    .m_stb_i (m_stb_i),
    .m_ack_o (m_ack_o),
    .s_cyc_o (s_cyc_o),
    .gnt_vld (gnt_vld),
    .gnt_idx (gnt_idx)
);

// File: tb/tb_wb_shared_fabric.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_wb_shared_fabric;
    import wbf_pkg::*;

    localparam int NM = 4;

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic [NM*WBF_AW-1:0]        m_adr = '0;
    logic [NM*WBF_DW-1:0]        m_dat = '0;
    logic [NM*WBF_SW-1:0]        m_sel = '0;
    logic [NM-1:0]               m_we = '0;
    logic [NM-1:0]               m_cyc = '0;
    logic [NM-1:0]               m_stb = '0;
    logic [NM*WBF_DW-1:0]        m_dat_o;
    logic [NM-1:0]               m_ack_o;
    logic [WBF_AW-1:0]           s_adr_o;
    logic [WBF_DW-1:0]           s_dat_o;
    logic [WBF_SW-1:0]           s_sel_o;
    logic                        s_we_o;
    logic [WBF_SLOTS-1:0]        s_cyc_o;
    logic [WBF_SLOTS-1:0]        s_stb_o;
    logic [WBF_SLOTS*WBF_DW-1:0] s_dat_i;
    logic [WBF_SLOTS-1:0]        s_ack_i;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #2.5 clk = ~clk;

    wb_shared_fabric dut (
        .clk(clk), .rst_n(rst_n),
        .m_adr_i(m_adr), .m_dat_i(m_dat), .m_sel_i(m_sel),
        .m_we_i(m_we), .m_cyc_i(m_cyc), .m_stb_i(m_stb),
        .m_dat_o(m_dat_o), .m_ack_o(m_ack_o),
        .s_adr_o(s_adr_o), .s_dat_o(s_dat_o), .s_sel_o(s_sel_o),
        .s_we_o(s_we_o), .s_cyc_o(s_cyc_o), .s_stb_o(s_stb_o),
        .s_dat_i(s_dat_i), .s_ack_i(s_ack_i)
    );

    // Read data that the slave model in a given slot returns.
    function automatic logic [31:0] rd_val(input int slot, input logic [WBF_AW-1:0] a);
        return {slot[1:0], 2'b01, a[27:0]};
    endfunction

    // Slave model: instant ack; slot 2 drives junk that must be ignored.
    always_comb begin
        for (int k = 0; k < WBF_SLOTS; k++) begin
            if (k == 2) begin
                s_ack_i[k] = 1'b1;
                s_dat_i[k*WBF_DW +: WBF_DW] = 32'hDEAD_BEEF;
            end else begin
                s_ack_i[k] = s_stb_o[k];
                s_dat_i[k*WBF_DW +: WBF_DW] = rd_val(k, s_adr_o);
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [WBF_AW-1:0] mk_adr(input int slot, input logic [27:0] off);
        return {slot[1:0], off};
    endfunction

    task automatic drive(input int i, input bit on, input bit we, input int slot,
                         input logic [27:0] off, input logic [31:0] d, input logic [3:0] sel);
        m_cyc[i] = on;
        m_stb[i] = on;
        m_we[i]  = we;
        m_adr[i*WBF_AW +: WBF_AW] = mk_adr(slot, off);
        m_dat[i*WBF_DW +: WBF_DW] = d;
        m_sel[i*WBF_SW +: WBF_SW] = sel;
    endtask

    task automatic release_all();
        for (int i = 0; i < NM; i++) drive(i, 0, 0, 0, 28'h0, 32'h0, 4'h0);
    endtask

    // R1: idle state during and right after reset.
    task automatic t_reset();
        drive(1, 1, 0, 1, 28'h10, 32'h0, 4'hF);
        @(negedge clk);
        chk("R1", "s_cyc in reset", 32'(s_cyc_o), 32'h0);
        chk("R1", "m_ack in reset", 32'(m_ack_o), 32'h0);
        release_all();
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "s_cyc after reset", 32'(s_cyc_o), 32'h0);
        chk("R1", "m_ack after reset", 32'(m_ack_o), 32'h0);
        chk("R4", "s_adr idle", 32'(s_adr_o), 32'h0);
    endtask

    // R4/R5/R6: single master write then read to a given slot.
    task automatic t_single(input int i, input int slot);
        logic [27:0] off = 28'h0ABC_000 + 28'(slot * 16 + i);
        logic [WBF_AW-1:0] a = mk_adr(slot, off);
        drive(i, 1, 1, slot, off, 32'hC0DE_0000 + 32'(i), 4'b0101);
        @(negedge clk);
        chk("R4", "s_adr", 32'(s_adr_o), 32'(a));
        chk("R4", "s_dat", s_dat_o, 32'hC0DE_0000 + 32'(i));
        chk("R4", "s_sel", 32'(s_sel_o), 32'h5);
        chk("R4", "s_we", 32'(s_we_o), 32'h1);
        chk("R5", "s_cyc slot", 32'(s_cyc_o), 32'(1 << slot));
        chk("R5", "s_stb slot", 32'(s_stb_o), 32'(1 << slot));
        chk("R6", "owner ack", 32'(m_ack_o), 32'(1 << i));
        m_we[i] = 1'b0;
        #1;
        chk("R4", "s_we read", 32'(s_we_o), 32'h0);
        chk("R6", "read data", m_dat_o[i*WBF_DW +: WBF_DW], rd_val(slot, a));
        release_all();
        @(negedge clk);
        chk("R4", "s_cyc released", 32'(s_cyc_o), 32'h0);
    endtask

    // R2/R3/R6: hold, rotation with skip, wrap-around.
    task automatic t_rotate();
        drive(0, 1, 0, 0, 28'h100, 32'h0, 4'hF);
        drive(1, 1, 0, 1, 28'h200, 32'h0, 4'hF);
        drive(3, 1, 0, 3, 28'h300, 32'h0, 4'hF);
        @(negedge clk);
        chk("R3", "first owner", 32'(m_ack_o), 32'h1);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R2", "held owner ack", 32'(m_ack_o), 32'h1);
            chk("R6", "waiting m1 data", m_dat_o[1*WBF_DW +: WBF_DW], 32'h0);
            chk("R5", "held slot", 32'(s_cyc_o), 32'h1);
        end
        drive(0, 0, 0, 0, 28'h0, 32'h0, 4'h0);
        @(negedge clk);
        chk("R3", "next after 0", 32'(m_ack_o), 32'h2);
        chk("R6", "m1 data", m_dat_o[1*WBF_DW +: WBF_DW], rd_val(1, mk_adr(1, 28'h200)));
        drive(1, 0, 0, 0, 28'h0, 32'h0, 4'h0);
        @(negedge clk);
        chk("R3", "skip idle m2", 32'(m_ack_o), 32'h8);
        chk("R5", "m3 slot", 32'(s_cyc_o), 32'h8);
        drive(0, 1, 0, 0, 28'h101, 32'h0, 4'hF);
        drive(1, 1, 0, 1, 28'h201, 32'h0, 4'hF);
        drive(3, 0, 0, 0, 28'h0, 32'h0, 4'h0);
        @(negedge clk);
        chk("R3", "wrap to m0", 32'(m_ack_o), 32'h1);
        release_all();
        @(negedge clk);
    endtask

    // R7: empty slot answered internally, slot inputs ignored.
    task automatic t_hole();
        drive(2, 1, 0, 2, 28'h0F0, 32'h0, 4'hF);
        @(negedge clk);
        chk("R7", "no slave cycle", 32'(s_cyc_o), 32'h0);
        chk("R7", "hole ack", 32'(m_ack_o), 32'h4);
        chk("R7", "hole data", m_dat_o[2*WBF_DW +: WBF_DW], 32'h0);
        m_stb[2] = 1'b0;
        #1;
        chk("R7", "no ack without strobe", 32'(m_ack_o), 32'h0);
        release_all();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_single(0, 0);
        t_single(1, 1);
        t_single(2, 3);
        t_single(3, 1);
        t_rotate();
        t_hole();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule